// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic unit of a small accumulator-style core. In one combinational step it takes the accumulator value and a second operand, which comes from a data-memory location or from a literal. It forms one of four results: a copy of the operand, the operand's bitwise inverse, the operand minus one, or the sum of the accumulator and the operand. A single destination bit routes the result. It goes either to the accumulator or back to the memory location, and the block raises the matching write strobe.

Beside the result, the block keeps a registered status word with five condition flags. The flags are zero, negative, carry out of the top bit, carry out of the low nibble, and signed overflow. The flags are loaded on the rising clock edge whenever the operation strobe is high. Which flags change depends on the operation. A synchronous reset clears the whole status word. The core around the block handles instruction fetch, decoding and memory addressing.

Top module: `alu8_flags`

## Requirements
- R1: When `rst` is high at a rising clock edge, `stat_out` becomes 0x00 at that edge.
- R2: `stat_out` holds carry in bit 0, nibble carry in bit 1, zero in bit 2, overflow in bit 3 and negative in bit 4, and bits 7:5 are always 0.
- R3: With `op_sel` = 2'b11 (add), `res_out` = (`acc_in` + `opnd_in`) mod 256. Carry is set on a carry out of bit 7, nibble carry on a carry out of bit 3, and overflow when both addends share a sign and the result sign differs.
- R4: With `op_sel` = 2'b01 (complement), `res_out` is the bitwise inverse of `opnd_in` (0x55 gives 0xAA).
- R5: With `op_sel` = 2'b10 (decrement), `res_out` = (`opnd_in` - 1) mod 256 (3 gives 2). Carry, nibble carry and overflow are set as for the sum `opnd_in` + 0xFF, so 0x00 gives 0xFF with carry 0, and 0x80 gives 0x7F with overflow 1.
- R6: With `op_sel` = 2'b00 (move), `res_out` equals `opnd_in`. With `dest_sel` = 1 it is written back to the memory location; with `dest_sel` = 0 it is written to the accumulator.
- R7: While `op_en` is high, `dest_sel` = 0 raises `acc_we` only and `dest_sel` = 1 raises `file_we` only. Both strobes are never high together.
- R8: At an enabled edge, zero and negative are loaded from the result for every operation (zero when the result is 0x00, negative = result bit 7). Carry, nibble carry and overflow keep their old values on move and complement.
- R9: While `op_en` is low, both write strobes are low and `stat_out` keeps its value across clock edges.
- R10: Adding 0x38 and 0x2F gives 0x67 with C=0, DC=1, Z=0. Adding 0x9C and 0x64 gives 0x00 with C=1, DC=1, Z=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; status updates on the rising edge |
| rst | input | 1 | Synchronous reset, clears the status word |
| op_en | input | 1 | Operation strobe: enables write strobes and the flag update |
| op_sel | input | 2 | 00 move, 01 complement, 10 decrement, 11 add |
| dest_sel | input | 1 | 0 routes the result to the accumulator, 1 to the memory location |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Memory or literal operand |
| res_out | output | 8 | Combinational result |
| acc_we | output | 1 | Accumulator write strobe |
| file_we | output | 1 | Memory location write strobe |
| stat_out | output | 8 | Registered status word |

## Verification
The bench targets the edges of every flag. Nibble-carry sums such as 0x08 + 0x08 are tested without a full carry; a design that took the nibble carry from the wrong bit would miss them. Overflow is probed at 0x7F + 0x01, 0x80 + 0x80 and a decrement of 0x80; a design that derived overflow from the unsigned carry would get those wrong. Decrement of 0x00 must leave carry clear, which catches a design that treats decrement as a true borrow-subtract or leaves the carry untouched. Move and complement are checked to hold an old carry, so a design that clears carry on every operation, or that updates flags while the strobe is low, disagrees with the reference at the following edge.

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_en,
  input  logic [1:0]   op_sel,
  input  logic         dest_sel,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] opnd_in,
  output logic [W-1:0] res_out,
  output logic         acc_we,
  output logic         file_we,
  output logic [7:0]   stat_out
);
  localparam int H = W / 2;
  localparam int NF = 5;
  localparam logic [1:0] OP_MOV = 2'b00;
  localparam logic [1:0] OP_CPL = 2'b01;
  localparam logic [1:0] OP_DEC = 2'b10;
  localparam logic [1:0] OP_ADD = 2'b11;
  localparam int B_C = 0, B_DC = 1, B_Z = 2, B_OV = 3, B_N = 4;

  logic [W-1:0] lhs, rhs;
  logic [W:0]   sum;
  logic [H:0]   lo_sum;
  logic         arith, ovf;
  logic [NF-1:0] flags;

  always_comb begin
    lhs = opnd_in;
    rhs = '0;
    if (op_sel == OP_ADD) begin
      lhs = acc_in;
      rhs = opnd_in;
    end else if (op_sel == OP_DEC) begin
      rhs = '1;
    end
  end

  assign sum    = {1'b0, lhs} + {1'b0, rhs};
  assign lo_sum = {1'b0, lhs[H-1:0]} + {1'b0, rhs[H-1:0]};
  assign arith  = op_sel[1];
  assign ovf    = (lhs[W-1] == rhs[W-1]) && (sum[W-1] != lhs[W-1]);

  always_comb begin
    case (op_sel)
      OP_MOV:  res_out = opnd_in;
      OP_CPL:  res_out = ~opnd_in;
      default: res_out = sum[W-1:0];
    endcase
  end

  assign acc_we  = op_en & ~dest_sel;
  assign file_we = op_en & dest_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else if (op_en) begin
      flags[B_Z] <= (res_out == '0);
      flags[B_N] <= res_out[W-1];
      if (arith) begin
        flags[B_C]  <= sum[W];
        flags[B_DC] <= lo_sum[H];
        flags[B_OV] <= ovf;
      end
    end
  end

  assign stat_out = {{(8-NF){1'b0}}, flags};
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         op_en,
  input logic [1:0]   op_sel,
  input logic         dest_sel,
  input logic [W-1:0] res_out,
  input logic         acc_we,
  input logic         file_we,
  input logic [7:0]   stat_out
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> stat_out == 8'h00);

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst) stat_out[7:5] == 3'b000);

  // R7
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst) !(acc_we && file_we));

  // R7
  dest_route_chk: assert property (@(posedge clk) disable iff (rst)
    op_en |-> (acc_we == !dest_sel) && (file_we == dest_sel));

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    op_en |=> stat_out[2] == ($past(res_out) == '0));

  // R8
  neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
    op_en |=> stat_out[4] == $past(res_out[W-1]));

  // R8
  logic_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op_en && !op_sel[1]) |=> (stat_out[0] == $past(stat_out[0])) &&
                              (stat_out[1] == $past(stat_out[1])) &&
                              (stat_out[3] == $past(stat_out[3])));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !op_en |=> $stable(stat_out));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !op_en |-> !acc_we && !file_we);
endmodule

bind alu8_flags alu8_flags_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op_en(op_en), .op_sel(op_sel), .dest_sel(dest_sel),
  .res_out(res_out), .acc_we(acc_we), .file_we(file_we), .stat_out(stat_out)
);

// File: tb/alu8_flags_bench.sv
module alu8_flags_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_en = 1'b0;
  logic [1:0] op_sel = 2'b00;
  logic       dest_sel = 1'b0;
  logic [7:0] acc_in = 8'h00;
  logic [7:0] opnd_in = 8'h00;
  logic [7:0] res_out;
  logic       acc_we, file_we;
  logic [7:0] stat_out;

  int n_chk = 0;
  int n_bad = 0;
  int m_stat = 0;

  alu8_flags u_alu8_flags (
    .clk(clk), .rst(rst), .op_en(op_en), .op_sel(op_sel), .dest_sel(dest_sel),
    .acc_in(acc_in), .opnd_in(opnd_in), .res_out(res_out),
    .acc_we(acc_we), .file_we(file_we), .stat_out(stat_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step(input int op, input int d, input int a, input int b,
                      input int en, input string tag);
    int x, y, s, r, c, dc, ov, z, n;
    @(negedge clk);
    op_sel = op[1:0]; dest_sel = d[0]; acc_in = a[7:0]; opnd_in = b[7:0]; op_en = en[0];
    x = b; y = 0;
    if (op == 3) begin x = a; y = b; end
    else if (op == 2) y = 255;
    s  = x + y;
    c  = (s > 255) ? 1 : 0;
    dc = ((x % 16) + (y % 16) > 15) ? 1 : 0;
    ov = ((x >= 128) == (y >= 128) && ((s % 256) >= 128) != (x >= 128)) ? 1 : 0;
    case (op)
      0: r = b;
      1: r = 255 - b;
      default: r = s % 256;
    endcase
    #1;
    check({tag, " result"}, res_out, r);
    check({tag, " R7 acc_we"}, acc_we, (en != 0 && d == 0) ? 1 : 0);
    check({tag, " R7 file_we"}, file_we, (en != 0 && d != 0) ? 1 : 0);
    if (en != 0) begin
      z = (r == 0) ? 1 : 0;
      n = (r >= 128) ? 1 : 0;
      if (op >= 2) m_stat = c + 2*dc + 4*z + 8*ov + 16*n;
      else m_stat = (m_stat & 11) + 4*z + 16*n;
    end
    @(posedge clk);
    #1;
    check({tag, " R2/R8 status"}, stat_out, m_stat);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset status", stat_out, 0);
    @(negedge clk); rst = 1'b0;
    m_stat = 0;

    step(3, 0, 8'h38, 8'h2F, 1, "R10 add 38+2F");
    check("R10 flags 38+2F", stat_out, 8'h02);
    step(3, 1, 8'h9C, 8'h64, 1, "R10 add 9C+64");
    check("R10 flags 9C+64", stat_out, 8'h07);
    step(1, 1, 0, 8'h55, 1, "R4 cpl 55");
    check("R4 cpl holds carry", stat_out, 8'h13);
    step(2, 1, 0, 3, 1, "R5 dec 3");
    step(2, 0, 0, 0, 1, "R5 dec 00");
    step(2, 0, 0, 8'h80, 1, "R5 dec 80");
    step(3, 0, 8'h7F, 8'h01, 1, "R3 add 7F+01");
    step(3, 0, 8'h80, 8'h80, 1, "R3 add 80+80");
    step(3, 0, 8'h08, 8'h08, 1, "R3 add 08+08");
    step(3, 0, 8'hFF, 8'h01, 1, "R3 add FF+01");
    step(0, 1, 8'h12, 8'hA5, 1, "R6 move to file");
    step(0, 0, 8'h12, 8'h00, 1, "R6 move to acc");
    step(3, 0, 8'hF0, 8'h20, 0, "R9 idle add");
    step(1, 1, 0, 8'hFF, 0, "R9 idle cpl");

    for (int i = 0; i < 256; i++)
      step(2, i % 2, 0, i, 1, "R5 dec sweep");
    for (int i = 0; i < 600; i++)
      step($urandom % 4, $urandom % 2, $urandom % 256, $urandom % 256,
           ($urandom % 5) != 0 ? 1 : 0, "R3 mixed");

    @(negedge clk); rst = 1'b1; op_en = 1'b1;
    @(posedge clk); #1;
    check("R1 reset mid-run", stat_out, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule